// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This controller turns a single host request into the bus traffic that a byte-wide parallel flash device needs to program one byte or erase a sector or the whole array. The host side is a simple valid/acknowledge handshake. It carries an operation code, a target address, a data byte and a choice of completion-detection method. The flash side is a chip enable, an output enable and a write strobe, all active low, plus an address bus and a data bus split into out, in and drive-enable.

After a request is accepted, the block emits the unlock-and-command write cycles for the chosen operation. Every strobe edge is placed by clock-count parameters. The block then releases the data bus and reads the target address repeatedly until the device reports completion. Completion is found either from bit 7 carrying the true data value rather than its complement, or from bit 6 no longer changing between consecutive reads. Each operation type has its own cycle limit. When that limit runs out, the block reports a timeout instead of done.

Top module: `flash_pe_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the block holds `fl_ce_n`, `fl_oe_n` and `fl_we_n` high, keeps `fl_dq_oe` low, and keeps `req_ack`, `op_done` and `op_timeout` low. This also applies when reset arrives in the middle of an operation.
- R2: `req_op` = 2'b00 (program) produces exactly four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_data`).
- R3: `req_op` = 2'b01 (sector erase) produces exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (`req_addr`, 30h).
- R4: `req_op` = 2'b10 or 2'b11 (chip erase) produces the same first five writes as R3, with (5555h, 10h) as the sixth.
- R5: For each write, address and data are presented and `fl_oe_n` is high before `fl_we_n` falls. `fl_we_n` stays low for exactly `T_WP` cycles, with address and data unchanged while it is low. `fl_we_n` stays high for at least `T_WPH` cycles before the next write or the first read.
- R6: `fl_dq_oe` is never high while `fl_oe_n` is low. Every polling read addresses `req_addr`. Before each read, `fl_oe_n` is high for at least `T_OEH` cycles, and it stays low for exactly `T_RD` cycles.
- R7: With `req_toggle` = 0, the operation completes on the first read whose bit 7 equals the expected bit: `req_data[7]` for a program, 1 for an erase.
- R8: With `req_toggle` = 1, the operation completes on the first read whose bit 6 equals bit 6 of the read just before it. The first read of an operation never completes it.
- R9: If the operation has not completed, `op_timeout` rises exactly `T_WPH + limit` cycles after the last rising edge of `fl_we_n`, and `op_done` does not rise. The limit is `TO_PROG` for a program and `TO_ERASE` for an erase.
- R10: `req_ack` is a one-cycle pulse given only when the block is idle. A request raised during an operation gets no acknowledge and causes no extra writes.
- R11: `op_done` and `op_timeout` are one-cycle pulses that never coincide. In the cycle they are high, the bus is already back to idle: `fl_ce_n` and `fl_oe_n` high, `fl_dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr | input | AW | Target byte / sector address, also the polling address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | 1: bit-6 toggle detection, 0: bit-7 data polling |
| req_ack | output | 1 | Request accepted (one cycle) |
| op_done | output | 1 | Operation completed (one cycle) |
| op_timeout | output | 1 | Operation limit expired (one cycle) |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Write data toward flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Read data from flash |

## Verification
The bench targets the toggle corner where the last busy read and the first settled read happen to share bit 6. A design that compared against a stale previous byte, or let the first read complete, would finish one read early or late, and the per-request read count exposes that. Data polling is exercised with programmed bytes whose bit 7 is 0 and 1 and with zero busy reads. A design that polled for a fixed polarity would hang in one of these cases or finish at once in another. Timeout is measured to the exact cycle for both limits, which catches an off-by-one counter or a swapped limit. A request held high through a whole operation checks that nothing is re-accepted and that no write cycle is emitted a second time.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WLOW, ST_WHIGH, ST_RSET, ST_RLOW
  } fseq_state_t;

  localparam logic [1:0]  OP_PROG   = 2'b00;
  localparam logic [1:0]  OP_SECTOR = 2'b01;
  localparam logic [14:0] UNLOCK_A  = 15'h5555;
  localparam logic [14:0] UNLOCK_B  = 15'h2AAA;
endpackage

// File: rtl/fseq_cmd_step.sv
module fseq_cmd_step
  import fseq_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic [1:0]    op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [2:0]    n_steps
);
  localparam logic [AW-1:0] ADR_A = AW'(UNLOCK_A);
  localparam logic [AW-1:0] ADR_B = AW'(UNLOCK_B);

  logic is_erase;
  assign is_erase = (op != OP_PROG);
  assign n_steps  = is_erase ? 3'd6 : 3'd4;

  always_comb begin
    case (step)
      3'd0: begin wr_addr = ADR_A; wr_data = 8'hAA; end
      3'd1: begin wr_addr = ADR_B; wr_data = 8'h55; end
      3'd2: begin wr_addr = ADR_A; wr_data = is_erase ? 8'h80 : 8'hA0; end
      3'd3: begin
        wr_addr = is_erase ? ADR_A : tgt_addr;
        wr_data = is_erase ? 8'hAA : tgt_data;
      end
      3'd4: begin wr_addr = ADR_B; wr_data = 8'h55; end
      default: begin
        wr_addr = op[1] ? ADR_A : tgt_addr;
        wr_data = op[1] ? 8'h10 : 8'h30;
      end
    endcase
  end
endmodule

// File: rtl/fseq_poll_judge.sv
module fseq_poll_judge (
  input  logic [7:0] rd_byte,
  input  logic [7:0] prev_byte,
  input  logic       have_prev,
  input  logic       toggle_mode,
  input  logic       want7,
  output logic       finished
);
  always_comb begin
    if (toggle_mode) finished = have_prev && (rd_byte[6] == prev_byte[6]);
    else             finished = (rd_byte[7] == want7);
  end
endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
  import fseq_pkg::*;
#(
  parameter int AW       = 18,
  parameter int T_AS     = 1,
  parameter int T_WP     = 12,
  parameter int T_WPH    = 12,
  parameter int T_OEH    = 19,
  parameter int T_RD     = 7,
  parameter int TO_PROG  = 6250,
  parameter int TO_ERASE = 1250000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_toggle,
  output logic          req_ack,
  output logic          op_done,
  output logic          op_timeout,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);
  localparam int TMAX_A = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int TMAX_B = (T_WPH > T_OEH) ? T_WPH : T_OEH;
  localparam int TMAX_C = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMAX   = (TMAX_C > T_RD) ? TMAX_C : T_RD;
  localparam int CW     = $clog2(TMAX + 1);
  localparam int TOMAX  = (TO_ERASE > TO_PROG) ? TO_ERASE : TO_PROG;
  localparam int TW     = $clog2(TOMAX + 1);

  fseq_state_t   st;
  logic [CW-1:0] cnt;
  logic [2:0]    step_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          tog_q;
  logic [7:0]    prev_q;
  logic          have_prev_q;
  logic [TW-1:0] tmo_q;

  logic [1:0]    lut_op;
  logic [2:0]    lut_step;
  logic [AW-1:0] lut_addr;
  logic [7:0]    lut_data;
  logic [2:0]    lut_len;
  logic          fin;
  logic          want7;
  logic [TW-1:0] lim;
  logic          last_step, hit, expire, polling;

  assign lut_op   = (st == ST_IDLE) ? req_op : op_q;
  assign lut_step = (st == ST_IDLE) ? 3'd0 : step_q + 3'd1;

  fseq_cmd_step #(.AW(AW)) u_step (
    .op(lut_op), .step(lut_step), .tgt_addr(addr_q), .tgt_data(data_q),
    .wr_addr(lut_addr), .wr_data(lut_data), .n_steps(lut_len)
  );

  assign want7 = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  fseq_poll_judge u_judge (
    .rd_byte(fl_dq_in), .prev_byte(prev_q), .have_prev(have_prev_q),
    .toggle_mode(tog_q), .want7(want7), .finished(fin)
  );

  assign lim       = (op_q == OP_PROG) ? TW'(TO_PROG) : TW'(TO_ERASE);
  assign last_step = (step_q == lut_len - 3'd1);
  assign polling   = (st == ST_RSET) || (st == ST_RLOW);
  assign hit       = (st == ST_RLOW) && (cnt == '0) && fin;
  assign expire    = polling && !hit && (tmo_q == lim - TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; step_q <= '0; op_q <= '0;
      addr_q <= '0; data_q <= '0; tog_q <= 1'b0;
      prev_q <= '0; have_prev_q <= 1'b0; tmo_q <= '0;
      req_ack <= 1'b0; op_done <= 1'b0; op_timeout <= 1'b0;
      fl_ce_n <= 1'b1; fl_oe_n <= 1'b1; fl_we_n <= 1'b1;
      fl_addr <= '0; fl_dq_out <= '0; fl_dq_oe <= 1'b0;
    end else begin
      req_ack    <= 1'b0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q <= req_op; addr_q <= req_addr; data_q <= req_data;
          tog_q <= req_toggle; step_q <= '0; req_ack <= 1'b1;
          cnt <= CW'(T_AS - 1); st <= ST_WSET; fl_ce_n <= 1'b0;
          fl_addr <= lut_addr; fl_dq_out <= lut_data; fl_dq_oe <= 1'b1;
        end
        ST_WSET: if (cnt == '0) begin
          st <= ST_WLOW; cnt <= CW'(T_WP - 1); fl_we_n <= 1'b0;
        end else cnt <= cnt - CW'(1);
        ST_WLOW: if (cnt == '0) begin
          st <= ST_WHIGH; cnt <= CW'(T_WPH - 1); fl_we_n <= 1'b1;
        end else cnt <= cnt - CW'(1);
        ST_WHIGH: if (cnt != '0) cnt <= cnt - CW'(1);
        else if (last_step) begin
          st <= ST_RSET; cnt <= CW'(T_OEH - 1); fl_dq_oe <= 1'b0;
          fl_addr <= addr_q; tmo_q <= '0; have_prev_q <= 1'b0;
        end else begin
          step_q <= step_q + 3'd1; st <= ST_WSET; cnt <= CW'(T_AS - 1);
          fl_addr <= lut_addr; fl_dq_out <= lut_data;
        end
        ST_RSET: begin
          tmo_q <= tmo_q + TW'(1);
          if (cnt == '0) begin
            st <= ST_RLOW; cnt <= CW'(T_RD - 1); fl_oe_n <= 1'b0;
          end else cnt <= cnt - CW'(1);
        end
        ST_RLOW: begin
          tmo_q <= tmo_q + TW'(1);
          if (cnt != '0) cnt <= cnt - CW'(1);
          else begin
            fl_oe_n <= 1'b1; prev_q <= fl_dq_in; have_prev_q <= 1'b1;
            st <= ST_RSET; cnt <= CW'(T_OEH - 1);
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (hit || expire) begin
        st <= ST_IDLE; fl_ce_n <= 1'b1; fl_oe_n <= 1'b1;
        op_done <= hit; op_timeout <= expire;
      end
    end
  end

  // R5: output enable stays high during any write strobe
  a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_oe_n);
  // R5: strobe only with the chip selected
  a_r5_we_needs_ce: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);
  // R5: address and data hold still while the strobe is low
  a_r5_stable_strobe: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  // R6: no bus drive while the flash may be driving
  a_r6_bus_released: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);
  // R10: acknowledge is a single pulse issued from idle
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);
  a_r10_ack_from_idle: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> $past(fl_ce_n));
  // R11: completion flags exclusive, single cycle, bus idle
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(op_done && op_timeout));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (op_done || op_timeout) |=> (!op_done && !op_timeout));
  a_r11_idle_bus: assert property (@(posedge clk) disable iff (rst)
    (op_done || op_timeout) |-> (fl_ce_n && fl_oe_n && !fl_dq_oe));
endmodule

// File: tb/flash_pe_sequencer_test.sv
module flash_pe_sequencer_test;
  localparam int AW = 18, T_AS = 1, T_WP = 12, T_WPH = 12, T_OEH = 19, T_RD = 7;
  localparam int TO_PROG = 400, TO_ERASE = 900;

  typedef struct packed {
    logic [1:0]  op;
    logic [17:0] addr;
    logic [7:0]  data;
    logic        tog;
    logic [7:0]  busy;
  } vec_t;

  localparam vec_t VT [0:7] = '{
    '{2'b00, 18'h04123, 8'h5A, 1'b0, 8'd3},
    '{2'b00, 18'h3FFFF, 8'hA5, 1'b0, 8'd0},
    '{2'b00, 18'h00000, 8'h00, 1'b1, 8'd4},
    '{2'b01, 18'h20000, 8'h00, 1'b0, 8'd5},
    '{2'b01, 18'h06000, 8'h00, 1'b1, 8'd2},
    '{2'b10, 18'h1C000, 8'h00, 1'b0, 8'd1},
    '{2'b11, 18'h2A5A5, 8'h00, 1'b1, 8'd0},
    '{2'b00, 18'h12345, 8'h7F, 1'b1, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_toggle = 1'b0;
  logic req_ack, op_done, op_timeout, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;

  always #4 clk = ~clk;

  flash_pe_sequencer #(.AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_WPH(T_WPH),
    .T_OEH(T_OEH), .T_RD(T_RD), .TO_PROG(TO_PROG), .TO_ERASE(TO_ERASE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
    .req_ack(req_ack), .op_done(op_done), .op_timeout(op_timeout),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in));

  int n_checks = 0, n_fail = 0;
  bit reported = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model and bus monitor
  logic [25:0] wr_log [0:63];
  int wr_total = 0, rd_total = 0, wr_base = 0, rd_base = 0, cur_rd;
  int last_rise = 0, timing_bad = 0, bus_bad = 0, addr_bad = 0;
  int we_lo = 0, oe_hi = 0, oe_lo = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [7:0] model_true = 8'hFF, model_busy = 8'd0;
  logic [AW-1:0] exp_poll_addr = '0;

  assign cur_rd = rd_total - rd_base;
  assign fl_dq_in = (cur_rd <= int'(model_busy)) ?
                    {~model_true[7], cur_rd[0], 6'h15} : model_true;

  always @(negedge clk) begin
    prev_we <= fl_we_n;
    prev_oe <= fl_oe_n;
    we_lo <= fl_we_n ? 0 : we_lo + 1;
    if (!fl_oe_n && fl_dq_oe) bus_bad <= bus_bad + 1;
    if (prev_we && !fl_we_n && (fl_ce_n || !fl_dq_oe || !fl_oe_n)) timing_bad <= timing_bad + 1;
    if (!prev_we && fl_we_n) begin
      wr_log[wr_total[5:0]] <= {fl_addr, fl_dq_out};
      wr_total <= wr_total + 1;
      last_rise <= cyc;
      if (we_lo != T_WP) timing_bad <= timing_bad + 1;
    end
    if (fl_oe_n) begin
      oe_lo <= 0;
      oe_hi <= fl_ce_n ? 0 : oe_hi + 1;
    end else begin
      oe_lo <= oe_lo + 1;
    end
    if (prev_oe && !fl_oe_n) begin
      rd_total <= rd_total + 1;
      oe_hi <= 0;
      if (oe_hi < T_OEH) timing_bad <= timing_bad + 1;
      if (fl_addr != exp_poll_addr) addr_bad <= addr_bad + 1;
    end
    if (!prev_oe && fl_oe_n && oe_lo != T_RD) timing_bad <= timing_bad + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    end
  endtask

  function automatic logic [25:0] exp_wr(input logic [1:0] op, input int i,
                                         input logic [17:0] a, input logic [7:0] d);
    if (op == 2'b00) begin
      case (i)
        0: return {18'h05555, 8'hAA};
        1: return {18'h02AAA, 8'h55};
        2: return {18'h05555, 8'hA0};
        default: return {a, d};
      endcase
    end
    case (i)
      0, 3: return {18'h05555, 8'hAA};
      1, 4: return {18'h02AAA, 8'h55};
      2: return {18'h05555, 8'h80};
      default: return (op == 2'b01) ? {a, 8'h30} : {18'h05555, 8'h10};
    endcase
  endfunction

  function automatic int exp_reads(input logic tog, input int busy, input logic t6);
    if (!tog) return busy + 1;
    for (int k = 2; k < 600; k++) begin
      logic rk, rp;
      rk = (k <= busy) ? k[0] : t6;
      rp = ((k - 1) <= busy) ? ((k - 1) % 2 == 1) : t6;
      if (rk == rp) return k;
    end
    return -1;
  endfunction

  task automatic start_op(input logic [1:0] op, input logic [17:0] a, input logic [7:0] d,
                          input logic tog, input logic [7:0] busy);
    int n;
    @(negedge clk);
    model_true = (op == 2'b00) ? d : 8'hFF;
    model_busy = busy;
    rd_base = rd_total;
    wr_base = wr_total;
    exp_poll_addr = a;
    req_op = op; req_addr = a; req_data = d; req_toggle = tog; req_valid = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ack && n < 50);
    req_valid = 1'b0;
    check(req_ack == 1'b1, "R10 ack from idle", req_ack, 1);
  endtask

  task automatic wait_end(output logic d, output logic t);
    int n = 0;
    while (!op_done && !op_timeout && n < 4000) begin @(negedge clk); n++; end
    d = op_done; t = op_timeout;
    if (n >= 4000) check(1'b0, "watchdog: no completion", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog: run hung", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    logic d, t;
    int acks, nw, bad, tlat;
    string tag;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 bus idle in reset",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    check(!req_ack && !op_done && !op_timeout, "R1 flags low in reset",
          {req_ack, op_done, op_timeout}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 bus idle after reset",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);

    // table walk: R2 R3 R4 R7 R8 R11
    for (int v = 0; v < 8; v++) begin
      vec_t e;
      int er, gr;
      e = VT[v];
      start_op(e.op, e.addr, e.data, e.tog, e.busy);
      wait_end(d, t);
      tag = e.tog ? "R8 toggle completion" : "R7 polling completion";
      check(d && !t, tag, {d, t}, 2'b10);
      check(fl_ce_n && fl_oe_n && !fl_dq_oe, "R11 bus idle at done",
            {fl_ce_n, fl_oe_n, fl_dq_oe}, 3'b110);
      nw = (e.op == 2'b00) ? 4 : 6;
      tag = (e.op == 2'b00) ? "R2 program writes" :
            (e.op == 2'b01) ? "R3 sector erase writes" : "R4 chip erase writes";
      check(wr_total - wr_base == nw, tag, wr_total - wr_base, nw);
      bad = 0;
      for (int i = 0; i < nw; i++) begin
        logic [25:0] got, exw;
        got = wr_log[(wr_base + i) % 64];
        exw = exp_wr(e.op, i, e.addr, e.data);
        if (got != exw) begin
          bad++;
          check(1'b0, tag, got, exw);
        end
      end
      if (bad == 0) check(1'b1, tag, 0, 0);
      er = exp_reads(e.tog, int'(e.busy), (e.op == 2'b00) ? e.data[6] : 1'b1);
      gr = rd_total - rd_base;
      tag = e.tog ? "R8 read count" : "R7 read count";
      check(gr == er, tag, gr, er);
      @(negedge clk);
      check(!op_done && !op_timeout, "R11 single-cycle flag", {op_done, op_timeout}, 0);
    end
    check(timing_bad == 0, "R5 R6 strobe timing", timing_bad, 0);
    check(bus_bad == 0, "R6 bus released before read", bus_bad, 0);
    check(addr_bad == 0, "R6 polling address", addr_bad, 0);

    // R10: request held high during an operation is ignored
    start_op(2'b00, 18'h0ABCD, 8'hC3, 1'b0, 8'd4);
    repeat (40) @(negedge clk);
    req_op = 2'b10; req_valid = 1'b1;
    acks = 0;
    while (!op_done && !op_timeout) begin
      @(negedge clk);
      if (req_ack) acks++;
    end
    req_valid = 1'b0;
    check(acks == 0, "R10 no ack while busy", acks, 0);
    check(wr_total - wr_base == 4, "R10 no extra writes", wr_total - wr_base, 4);
    check(op_done == 1'b1, "R10 original op completes", op_done, 1);
    @(negedge clk);

    // R9: program timeout
    start_op(2'b00, 18'h00777, 8'h11, 1'b0, 8'd255);
    wait_end(d, t);
    tlat = cyc - last_rise;
    check(t && !d, "R9 program timeout flag", {d, t}, 2'b01);
    check(tlat == T_WPH + TO_PROG, "R9 program timeout cycle", tlat, T_WPH + TO_PROG);
    @(negedge clk);

    // R9: erase timeout uses its own limit
    start_op(2'b01, 18'h30000, 8'h00, 1'b1, 8'd255);
    wait_end(d, t);
    tlat = cyc - last_rise;
    check(t && !d, "R9 erase timeout flag", {d, t}, 2'b01);
    check(tlat == T_WPH + TO_ERASE, "R9 erase timeout cycle", tlat, T_WPH + TO_ERASE);
    @(negedge clk);

    // R1: reset in the middle of a write sequence
    start_op(2'b01, 18'h08000, 8'h00, 1'b0, 8'd0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 mid-op reset idles bus",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(fl_ce_n && !op_done && !op_timeout, "R1 stays idle after reset",
          {fl_ce_n, op_done, op_timeout}, 3'b100);

    summary();
    $finish;
  end
endmodule